// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer with Tail-Chaining

This block runs interrupt entry and exit for a small processor core. When a request is pending, it saves an eight-word register context to a full-descending stack in memory. It then pulses a handler-start output carrying the vector number. When the handler signals that it is done, the block restores the context from the stack and the core resumes the code it interrupted. Every stack transfer goes over one shared memory bus with a valid/ready handshake, so the length of each save or restore depends on how often the bus is stalled.

If a further request is already latched when the handler signals it is done, the block skips the restore and the save that would follow it. It starts the next handler at once and counts the skipped pair. The context is then restored only once, after the last handler in the chain has finished. A request that arrives after the restore has begun is not chained. The restore runs to the end, and a full save is made before the new handler starts.

Top module: `irq_ctx_seq`

## Requirements
- R1: While reset is held and after it is released, `stack_ptr` equals `SP_INIT`, `chain_cnt` is 0, and `mem_valid`, `hnd_start`, `hnd_active` and `irq_ack` are low.
- R2: Entry makes exactly eight write beats. Beat k (k = 0..7) stores context slot k (slot order: 0 r0, 1 r1, 2 r2, 3 r3, 4 r12, 5 r14, 6 r15, 7 status word) at address `SP_INIT - 4*(k+1)`. `stack_ptr` drops by 4 per beat and ends at `SP_INIT - 32`.
- R3: A beat completes only in a cycle where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_addr`, `mem_write` and `mem_wdata` are held unchanged.
- R4: In the cycle after the last save beat, `hnd_start` is high for exactly one cycle and `hnd_vec` shows the vector being serviced. `hnd_active` rises in the same cycle.
- R5: A return with nothing latched drops `hnd_active` in the next cycle. The block then makes eight read beats from ascending addresses starting at `SP_INIT - 32` and writes slots 7 down to 0 back into the register file. `stack_ptr` ends at `SP_INIT`.
- R6: A return while a request is latched pulses `hnd_start` in the next cycle with the latched vector. It makes no bus beat, leaves `stack_ptr` unchanged, keeps `hnd_active` high and increments `chain_cnt` by one.
- R7: A request that arrives while a save is in progress is latched. It is serviced through tail-chaining at the next return.
- R8: A request that arrives after a restore has begun lets all eight read beats complete. Eight write beats follow, and then `hnd_start` is pulsed with the new vector. `chain_cnt` is not changed.
- R9: A return strobe while no handler is active causes no bus beat, no `hnd_start` pulse and no change to `stack_ptr`.
- R10: `irq_ack` is high in the cycle a request is captured into the one-entry latch. It stays low while the latch is full, even if `irq_req` is held high.
- R11: After a chain of handlers, the single final restore brings back the context saved at the first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Interrupt request present |
| irq_vec | input | VEC_W | Vector number of the request |
| irq_ack | output | 1 | Request captured this cycle |
| ret_stb | input | 1 | Handler-return strobe |
| hnd_start | output | 1 | One-cycle handler-start pulse |
| hnd_vec | output | VEC_W | Vector of the handler being started |
| hnd_active | output | 1 | High while a handler runs |
| chain_cnt | output | CHAIN_W | Number of skipped restore/save pairs |
| rf_slot | output | 3 | Context slot being read or written |
| rf_rdata | input | DW | Register-file read data for `rf_slot` |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | DW | Register-file write data |
| mem_valid | output | 1 | Bus request valid |
| mem_write | output | 1 | Bus request is a write |
| mem_addr | output | AW | Bus byte address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data |
| mem_ready | input | 1 | Bus accepts the beat |
| stack_ptr | output | AW | Current stack pointer |

## Verification
The hardest case to reach is the boundary of the tail-chain decision: one request latched before the return strobe, and another that arrives only after the restore has started. The bench stretches the save and restore by toggling `mem_ready`, which leaves wide windows for these arrivals. It raises the second request once it sees `mem_valid` high during a save, and again during a restore. It then compares the beat counts and beat timestamps to tell a chained handover from a full restore followed by a full save. A latch-full attempt made during a handler confirms that only the first latched request is chained.

// File: rtl/irq_ctx_pkg.sv
`timescale 1ns/1ps
package irq_ctx_pkg;
    localparam int CTX_WORDS = 8;
    localparam int SLOT_W    = $clog2(CTX_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_RUN  = 2'd2,
        ST_REST = 2'd3
    } seq_state_t;
endpackage

// File: rtl/irq_ctx_latch.sv
`timescale 1ns/1ps
module irq_ctx_latch #(
    parameter int VEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ack_o
);
    logic             pend_d, pend_q;
    logic [VEC_W-1:0] vec_d,  vec_q;

    always_comb begin
        ack_o  = req_i && !pend_q;
        pend_d = pend_q;
        vec_d  = vec_q;
        if (take_i) pend_d = 1'b0;
        if (ack_o) begin
            pend_d = 1'b1;
            vec_d  = vec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            pend_q <= pend_d;
            vec_q  <= vec_d;
        end
    end

    assign pend_o = pend_q;
    assign vec_o  = vec_q;

    p_take_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_q);
    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
endmodule

// File: rtl/irq_ctx_sp.sv
`timescale 1ns/1ps
module irq_ctx_sp #(
    parameter int             AW      = 32,
    parameter int             DW      = 32,
    parameter logic [AW-1:0]  SP_INIT = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_i,
    input  logic          inc_i,
    output logic [AW-1:0] sp_o
);
    import irq_ctx_pkg::*;
    localparam logic [AW-1:0] STEP   = AW'(DW / 8);
    localparam logic [AW-1:0] SP_LOW = SP_INIT - AW'(CTX_WORDS * (DW / 8));

    logic [AW-1:0] sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (dec_i)      sp_d = sp_q - STEP;
        else if (inc_i) sp_d = sp_q + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= SP_INIT;
        else        sp_q <= sp_d;
    end

    assign sp_o = sp_q;

    p_sp_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q <= SP_INIT) && (sp_q >= SP_LOW));
    p_sp_one_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_i && inc_i));
endmodule

// File: rtl/irq_ctx_seq.sv
`timescale 1ns/1ps
module irq_ctx_seq #(
    parameter int            AW      = 32,
    parameter int            DW      = 32,
    parameter int            VEC_W   = 6,
    parameter int            CHAIN_W = 8,
    parameter logic [AW-1:0] SP_INIT = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_req,
    input  logic [VEC_W-1:0]   irq_vec,
    output logic               irq_ack,
    input  logic               ret_stb,
    output logic               hnd_start,
    output logic [VEC_W-1:0]   hnd_vec,
    output logic               hnd_active,
    output logic [CHAIN_W-1:0] chain_cnt,
    output logic [2:0]         rf_slot,
    input  logic [DW-1:0]      rf_rdata,
    output logic               rf_we,
    output logic [DW-1:0]      rf_wdata,
    output logic               mem_valid,
    output logic               mem_write,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_ready,
    output logic [AW-1:0]      stack_ptr
);
    import irq_ctx_pkg::*;

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(CTX_WORDS - 1);
    localparam logic [AW-1:0]     STEP = AW'(DW / 8);

    typedef struct packed {
        seq_state_t         st;
        logic [SLOT_W-1:0]  cnt;
        logic [VEC_W-1:0]   cur_vec;
        logic               start;
        logic [VEC_W-1:0]   start_vec;
        logic               active;
        logic [CHAIN_W-1:0] chains;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             pend;
    logic [VEC_W-1:0] pend_vec;
    logic             take;
    logic             beat;
    logic             sp_dec, sp_inc;

    irq_ctx_latch #(.VEC_W(VEC_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .vec_i  (irq_vec),
        .take_i (take),
        .pend_o (pend),
        .vec_o  (pend_vec),
        .ack_o  (irq_ack)
    );

    irq_ctx_sp #(.AW(AW), .DW(DW), .SP_INIT(SP_INIT)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_i (sp_dec),
        .inc_i (sp_inc),
        .sp_o  (stack_ptr)
    );

    // bus and register-file side, driven from the current state
    always_comb begin
        mem_valid = (r_q.st == ST_SAVE) || (r_q.st == ST_REST);
        mem_write = (r_q.st == ST_SAVE);
        mem_addr  = mem_write ? (stack_ptr - STEP) : stack_ptr;
        rf_slot   = '0;
        if (r_q.st == ST_SAVE)      rf_slot = r_q.cnt;
        else if (r_q.st == ST_REST) rf_slot = LAST - r_q.cnt;
        mem_wdata = mem_write ? rf_rdata : '0;
        beat      = mem_valid && mem_ready;
        rf_we     = beat && !mem_write;
        rf_wdata  = mem_rdata;
        sp_dec    = beat && mem_write;
        sp_inc    = beat && !mem_write;
    end

    // sequencing and tail-chain decision
    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        take      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (pend) begin
                    take      = 1'b1;
                    r_d.st    = ST_SAVE;
                    r_d.cnt   = '0;
                    r_d.cur_vec = pend_vec;
                end
            end
            ST_SAVE: begin
                if (beat) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST) begin
                        r_d.st        = ST_RUN;
                        r_d.cnt       = '0;
                        r_d.start     = 1'b1;
                        r_d.start_vec = r_q.cur_vec;
                        r_d.active    = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (ret_stb) begin
                    if (pend) begin
                        take          = 1'b1;
                        r_d.start     = 1'b1;
                        r_d.start_vec = pend_vec;
                        r_d.cur_vec   = pend_vec;
                        r_d.chains    = r_q.chains + 1'b1;
                    end else begin
                        r_d.st     = ST_REST;
                        r_d.cnt    = '0;
                        r_d.active = 1'b0;
                    end
                end
            end
            ST_REST: begin
                if (beat) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, cur_vec: '0, start: 1'b0,
                     start_vec: '0, active: 1'b0, chains: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hnd_start  = r_q.start;
    assign hnd_vec    = r_q.start_vec;
    assign hnd_active = r_q.active;
    assign chain_cnt  = r_q.chains;

    p_hold_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
            && $stable(mem_write) && $stable(mem_wdata)));
    p_start_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |-> hnd_active);
    p_quiet_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_active |-> !mem_valid);
    p_rest_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REST && beat && r_q.cnt == LAST) |=> (stack_ptr == SP_INIT));
    p_stray_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !pend && ret_stb) |=> ($stable(stack_ptr) && !hnd_start));
endmodule

// File: tb/sim_irq_ctx_seq.sv
`timescale 1ns/1ps
module sim_irq_ctx_seq;
    localparam int            AW      = 32;
    localparam int            DW      = 32;
    localparam int            VEC_W   = 6;
    localparam int            CHAIN_W = 8;
    localparam logic [31:0]   SP_INIT = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic               irq_req = 1'b0;
    logic [VEC_W-1:0]   irq_vec = '0;
    logic               irq_ack;
    logic               ret_stb = 1'b0;
    logic               hnd_start;
    logic [VEC_W-1:0]   hnd_vec;
    logic               hnd_active;
    logic [CHAIN_W-1:0] chain_cnt;
    logic [2:0]         rf_slot;
    logic [DW-1:0]      rf_rdata;
    logic               rf_we;
    logic [DW-1:0]      rf_wdata;
    logic               mem_valid, mem_write, mem_ready;
    logic [AW-1:0]      mem_addr, stack_ptr;
    logic [DW-1:0]      mem_wdata, mem_rdata;

    irq_ctx_seq #(.AW(AW), .DW(DW), .VEC_W(VEC_W), .CHAIN_W(CHAIN_W), .SP_INIT(SP_INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
        .ret_stb(ret_stb), .hnd_start(hnd_start), .hnd_vec(hnd_vec), .hnd_active(hnd_active),
        .chain_cnt(chain_cnt), .rf_slot(rf_slot), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .stack_ptr(stack_ptr)
    );

    // environment: memory, register file, beat logs
    logic [31:0] mem [0:1023];
    logic [31:0] rf  [0:7];
    logic        rf_load = 1'b0;
    logic [31:0] rf_base = '0;
    logic        rdy_mode = 1'b0;
    logic [1:0]  tick = '0;
    int wr_n = 0, rd_n = 0, n_start = 0, cyc = 0;
    logic [31:0] wlog_a [0:63];
    logic [31:0] wlog_d [0:63];
    int          wlog_c [0:63];
    logic [31:0] rlog_a [0:63];
    logic [2:0]  rlog_s [0:63];
    int          rlog_c [0:63];

    assign mem_ready = rdy_mode ? tick[0] : 1'b1;
    assign rf_rdata  = rf[rf_slot];
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        tick <= tick + 2'd1;
        if (hnd_start) n_start <= n_start + 1;
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                mem[mem_addr[11:2]] <= mem_wdata;
                wlog_a[wr_n % 64] <= mem_addr;
                wlog_d[wr_n % 64] <= mem_wdata;
                wlog_c[wr_n % 64] <= cyc;
                wr_n <= wr_n + 1;
            end else begin
                rlog_a[rd_n % 64] <= mem_addr;
                rlog_s[rd_n % 64] <= rf_slot;
                rlog_c[rd_n % 64] <= cyc;
                rd_n <= rd_n + 1;
            end
        end
        if (rf_we) rf[rf_slot] <= rf_wdata;
        else if (rf_load) for (int k = 0; k < 8; k++) rf[k] <= rf_base + 32'(k);
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_rf(input logic [31:0] base);
        @(negedge clk); rf_base = base; rf_load = 1'b1;
        @(negedge clk); rf_load = 1'b0;
    endtask

    task automatic raise_irq(input logic [VEC_W-1:0] v);
        int n = 0;
        irq_req = 1'b1; irq_vec = v; #1;
        while (!irq_ack && n < 1000) begin @(negedge clk); n++; end
        chk(irq_ack == 1'b1, "R10 ack on capture", 32'(irq_ack), 32'd1);
        @(negedge clk);
        chk(irq_ack == 1'b0, "R10 ack low once latched", 32'(irq_ack), 32'd0);
        irq_req = 1'b0;
    endtask

    task automatic wait_start(output int n);
        n = 0;
        while (!hnd_start && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_ret();
        ret_stb = 1'b1; @(negedge clk); ret_stb = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((mem_valid || hnd_active) && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic check_save(input int w0, input logic [31:0] base, input string tag);
        bit ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (wlog_a[(w0 + k) % 64] != SP_INIT - 32'(4 * (k + 1))) ok = 1'b0;
            if (wlog_d[(w0 + k) % 64] != base + 32'(k)) ok = 1'b0;
        end
        chk(wr_n - w0 == 8, {tag, " write beats"}, 32'(wr_n - w0), 32'd8);
        chk(ok, {tag, " save order/address/data"}, wlog_a[w0 % 64], SP_INIT - 32'd4);
        chk(stack_ptr == SP_INIT - 32'd32, {tag, " sp after save"}, stack_ptr, SP_INIT - 32'd32);
    endtask

    task automatic check_restore(input int r0, input logic [31:0] base, input string tag);
        bit ok = 1'b1;
        bit rok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (rlog_a[(r0 + k) % 64] != SP_INIT - 32'd32 + 32'(4 * k)) ok = 1'b0;
            if (rlog_s[(r0 + k) % 64] != 3'(7 - k)) ok = 1'b0;
            if (rf[k] != base + 32'(k)) rok = 1'b0;
        end
        chk(rd_n - r0 == 8, {tag, " read beats"}, 32'(rd_n - r0), 32'd8);
        chk(ok, {tag, " restore order/address"}, rlog_a[r0 % 64], SP_INIT - 32'd32);
        chk(rok, {tag, " register file restored"}, rf[0], base);
        chk(stack_ptr == SP_INIT, {tag, " sp after restore"}, stack_ptr, SP_INIT);
    endtask

    // R1: reset state
    task automatic t_reset();
        chk(stack_ptr == SP_INIT, "R1 sp in reset", stack_ptr, SP_INIT);
        chk(!mem_valid && !hnd_active && !hnd_start && !irq_ack, "R1 outputs low in reset",
            {mem_valid, hnd_active, hnd_start, irq_ack}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(stack_ptr == SP_INIT, "R1 sp after reset", stack_ptr, SP_INIT);
        chk(chain_cnt == 0 && !mem_valid && !hnd_active, "R1 idle after reset",
            32'(chain_cnt), 32'd0);
    endtask

    // R2 R4 R5: plain entry and exit, bus always ready
    task automatic t_basic();
        int w0, r0, n;
        load_rf(32'hA000_0000);
        w0 = wr_n;
        raise_irq(6'd5);
        wait_start(n);
        chk(hnd_start == 1'b1, "R4 start pulse seen", 32'(hnd_start), 32'd1);
        chk(hnd_vec == 6'd5 && hnd_active, "R4 vector and active", 32'(hnd_vec), 32'd5);
        check_save(w0, 32'hA000_0000, "R2");
        @(negedge clk);
        chk(hnd_start == 1'b0, "R4 pulse is one cycle", 32'(hnd_start), 32'd0);
        load_rf(32'h5555_0000);
        r0 = rd_n;
        pulse_ret();
        chk(hnd_active == 1'b0 && mem_valid, "R5 active drops after return", 32'(hnd_active), 32'd0);
        wait_idle();
        check_restore(r0, 32'hA000_0000, "R5");
    endtask

    // R9: stray return
    task automatic t_stray();
        int w0 = wr_n, r0 = rd_n, s0 = n_start;
        pulse_ret();
        repeat (5) @(negedge clk);
        chk(wr_n == w0 && rd_n == r0, "R9 no beats on stray return", 32'(wr_n + rd_n), 32'(w0 + r0));
        chk(n_start == s0 && !hnd_active, "R9 no handler start", 32'(n_start), 32'(s0));
        chk(stack_ptr == SP_INIT, "R9 sp unchanged", stack_ptr, SP_INIT);
    endtask

    // R3: stalled bus
    task automatic t_stall();
        int w0, r0, n;
        rdy_mode = 1'b1;
        load_rf(32'hB000_0010);
        w0 = wr_n;
        raise_irq(6'd9);
        wait_start(n);
        chk(n >= 12, "R3 stalls lengthen save", 32'(n), 32'd12);
        chk(hnd_vec == 6'd9, "R4 vector under stall", 32'(hnd_vec), 32'd9);
        check_save(w0, 32'hB000_0010, "R3");
        load_rf(32'h0);
        r0 = rd_n;
        pulse_ret();
        wait_idle();
        check_restore(r0, 32'hB000_0010, "R3");
        rdy_mode = 1'b0;
    endtask

    // R6 R10 R11: tail chain with a second request refused while latch is full
    task automatic t_chain();
        int w0, r0, n;
        logic [CHAIN_W-1:0] c0;
        bit acked = 1'b0;
        load_rf(32'hC000_0100);
        raise_irq(6'd3);
        wait_start(n);
        @(negedge clk);
        raise_irq(6'd4);
        irq_req = 1'b1; irq_vec = 6'd6;
        for (int k = 0; k < 3; k++) begin #1; if (irq_ack) acked = 1'b1; @(negedge clk); end
        irq_req = 1'b0;
        chk(!acked, "R10 no ack while latch full", 32'(acked), 32'd0);
        w0 = wr_n; r0 = rd_n; c0 = chain_cnt;
        pulse_ret();
        chk(hnd_start && hnd_vec == 6'd4, "R6 chained start with latched vector", 32'(hnd_vec), 32'd4);
        chk(chain_cnt == c0 + 1'b1, "R6 chain count", 32'(chain_cnt), 32'(c0 + 1'b1));
        repeat (3) @(negedge clk);
        chk(wr_n == w0 && rd_n == r0 && stack_ptr == SP_INIT - 32'd32, "R6 no bus traffic",
            32'(wr_n + rd_n - w0 - r0), 32'd0);
        chk(hnd_active == 1'b1, "R6 stays active", 32'(hnd_active), 32'd1);
        load_rf(32'hDEAD_0000);
        r0 = rd_n;
        pulse_ret();
        wait_idle();
        check_restore(r0, 32'hC000_0100, "R11");
        chk(n_start > 0 && chain_cnt == c0 + 1'b1, "R10 refused request never chained",
            32'(chain_cnt), 32'(c0 + 1'b1));
    endtask

    // R7: request during save is latched and chained
    task automatic t_during_save();
        int n;
        logic [CHAIN_W-1:0] c0 = chain_cnt;
        rdy_mode = 1'b1;
        load_rf(32'hE000_0000);
        raise_irq(6'd7);
        n = 0;
        while (!mem_valid && n < 100) begin @(negedge clk); n++; end
        chk(mem_valid && mem_write, "R7 save in progress", 32'(mem_valid), 32'd1);
        raise_irq(6'd8);
        wait_start(n);
        chk(hnd_vec == 6'd7 && chain_cnt == c0, "R7 first handler", 32'(hnd_vec), 32'd7);
        @(negedge clk);
        pulse_ret();
        chk(hnd_start && hnd_vec == 6'd8, "R7 chained to save-time request", 32'(hnd_vec), 32'd8);
        chk(chain_cnt == c0 + 1'b1, "R7 chain count", 32'(chain_cnt), 32'(c0 + 1'b1));
        pulse_ret();
        wait_idle();
        rdy_mode = 1'b0;
    endtask

    // R8: request during restore is not chained
    task automatic t_during_restore();
        int w0, r0, n;
        logic [CHAIN_W-1:0] c0;
        load_rf(32'hF000_0000);
        raise_irq(6'd10);
        wait_start(n);
        rdy_mode = 1'b1;
        @(negedge clk);
        w0 = wr_n; r0 = rd_n; c0 = chain_cnt;
        pulse_ret();
        @(negedge clk);
        chk(mem_valid && !mem_write, "R8 restore in progress", 32'(mem_valid), 32'd1);
        raise_irq(6'd11);
        wait_start(n);
        chk(hnd_vec == 6'd11, "R8 new handler vector", 32'(hnd_vec), 32'd11);
        chk(rd_n - r0 == 8 && wr_n - w0 == 8, "R8 full restore then full save",
            32'(rd_n - r0), 32'd8);
        chk(rlog_c[(r0 + 7) % 64] < wlog_c[w0 % 64], "R8 restore finishes before save",
            32'(rlog_c[(r0 + 7) % 64]), 32'(wlog_c[w0 % 64]));
        chk(chain_cnt == c0, "R8 chain count unchanged", 32'(chain_cnt), 32'(c0));
        @(negedge clk);
        pulse_ret();
        wait_idle();
        chk(stack_ptr == SP_INIT, "R8 sp home", stack_ptr, SP_INIT);
        rdy_mode = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        for (int k = 0; k < 8; k++) rf[k] = '0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stray();
        t_stall();
        t_chain();
        t_during_save();
        t_during_restore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule